// File: doc/BRIEF.md
# Vector Element Loop Step Sequencer

This block tracks where a vector instruction stands in its element loop. The instruction covers a vector length of VL elements, and each element holds one to four sub-elements. The block keeps two positions, one for the source side and one for the destination side. Each position is an element index together with a sub-element index. On every step pulse both positions move forward by one, and the end-of-loop condition is decoded from the values they now hold.

Each side has its own ordering bit. When the bit is clear, the sub-element index is the inner loop: it walks through every sub-element of an element before the element index moves on. When the bit is set, the nesting is reversed: the element index walks through every element for one sub-element position, then the sub-element index moves on. This lets a source be gathered in one order and its destination be scattered in the other. When the last position is reached, or when a step arrives outside vector mode, all indices return to zero so that the next instruction starts fresh.

Top module: `vec_step_seq`

## Requirements
- R1: A high `rst` at a rising clock edge clears all four indices to zero.
- R2: While `src_pack` is 0, an accepted source step does one of two things. If `src_sub` differs from `subvl`, it increments `src_sub`. Otherwise it sets `src_sub` to 0 and increments `src_elem`, unless `src_elem` is already the last element.
- R3: While `src_pack` is 1, an accepted source step does one of two things. If `src_elem` is not the last element, it increments `src_elem`. Otherwise it sets `src_elem` to 0 and increments `src_sub`, unless `src_sub` already equals `subvl`.
- R4: The destination side follows the same two orderings, chosen by `dst_unpack`. Its choice is made independently of the source side.
- R5: `src_end` or `dst_end` is 1 exactly when that side's element index equals the last element, `vl`-1.
- R6: `loop_end` is 1 exactly when (`src_end` and `src_sub`==`subvl`) or (`dst_end` and `dst_sub`==`subvl`).
- R7: A step taken while `vec_mode` is 0 or `loop_end` is 1 clears all four indices to zero.
- R8: With `step` low, no index changes.
- R9: A `vl` of 0 is treated as one element. The last element is then index 0, and the element index never leaves 0.
- R10: `done` is 1 when, for at least one side, the sub-element index equals `subvl` and the element index equals `vl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vec_mode | input | 1 | Instruction runs in vector mode |
| step | input | 1 | Single-cycle advance strobe |
| vl | input | ELEM_W | Vector length in elements |
| subvl | input | SUB_W | Sub-elements per element minus one |
| src_pack | input | 1 | 1: source sub-element index is the outer loop |
| dst_unpack | input | 1 | 1: destination sub-element index is the outer loop |
| src_elem | output | ELEM_W | Source element index |
| src_sub | output | SUB_W | Source sub-element index |
| dst_elem | output | ELEM_W | Destination element index |
| dst_sub | output | SUB_W | Destination sub-element index |
| src_end | output | 1 | Source element index at last element |
| dst_end | output | 1 | Destination element index at last element |
| loop_end | output | 1 | Final position of the loop reached |
| done | output | 1 | Completion test with element index equal to `vl` |

## Verification
The hardest case to reach is a step in which the two sides, running in different nesting orders, move differently. For example, one side wraps its element index while the other only bumps its sub-element index. The loop must still end on whichever side finishes first. The stimulus holds `src_pack` and `dst_unpack` at opposite values, uses VL and SUBVL values whose products differ in traversal shape, and walks through every step of the loop. The expected indices come from a separate next-state model in the bench. `done` can only be raised through the `vl`=0 corner, so that corner is driven on purpose.

// File: rtl/vss_pkg.sv
package vss_pkg;
   localparam int unsigned VSS_ELEM_W = 7;
   localparam int unsigned VSS_SUB_W  = 2;
   localparam int unsigned VSS_SIDES  = 2;

   typedef enum logic [0:0] {
      SIDE_SRC = 1'b0,
      SIDE_DST = 1'b1
   } vss_side_e;

   typedef enum logic [0:0] {
      ORD_SUB_INNER = 1'b0,
      ORD_SUB_OUTER = 1'b1
   } vss_order_e;
endpackage

// File: rtl/vss_last_calc.sv
module vss_last_calc #(
   parameter int unsigned ELEM_W = vss_pkg::VSS_ELEM_W
) (
   input  logic [ELEM_W-1:0] vl,
   output logic [ELEM_W-1:0] last_elem
);
   localparam logic [ELEM_W-1:0] ZERO = '0;
   localparam logic [ELEM_W-1:0] ONE  = ELEM_W'(1);

   always_comb begin
      if (vl == ZERO) last_elem = ZERO;
      else            last_elem = vl - ONE;
   end
endmodule

// File: rtl/vss_side.sv
module vss_side #(
   parameter int unsigned ELEM_W = vss_pkg::VSS_ELEM_W,
   parameter int unsigned SUB_W  = vss_pkg::VSS_SUB_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  logic              clr,
   input  vss_pkg::vss_order_e order,
   input  logic [ELEM_W-1:0] last_elem,
   input  logic [SUB_W-1:0]  subvl,
   output logic [ELEM_W-1:0] elem_o,
   output logic [SUB_W-1:0]  sub_o,
   output logic              elem_end_o,
   output logic              sub_end_o
);
   localparam logic [ELEM_W-1:0] E_ONE = ELEM_W'(1);
   localparam logic [SUB_W-1:0]  S_ONE = SUB_W'(1);

   logic [ELEM_W-1:0] elem_q, elem_d;
   logic [SUB_W-1:0]  sub_q, sub_d;
   logic              elem_end, sub_end;

   assign elem_end = (elem_q == last_elem);
   assign sub_end  = (sub_q == subvl);

   always_comb begin
      elem_d = elem_q;
      sub_d  = sub_q;
      if (clr) begin
         elem_d = '0;
         sub_d  = '0;
      end else if (adv) begin
         if (order == vss_pkg::ORD_SUB_OUTER) begin
            if (elem_end) begin
               elem_d = '0;
               if (!sub_end) sub_d = sub_q + S_ONE;
            end else begin
               elem_d = elem_q + E_ONE;
            end
         end else begin
            if (sub_end) begin
               sub_d = '0;
               if (!elem_end) elem_d = elem_q + E_ONE;
            end else begin
               sub_d = sub_q + S_ONE;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         elem_q <= '0;
         sub_q  <= '0;
      end else begin
         elem_q <= elem_d;
         sub_q  <= sub_d;
      end
   end

   assign elem_o     = elem_q;
   assign sub_o      = sub_q;
   assign elem_end_o = elem_end;
   assign sub_end_o  = sub_end;
endmodule

// File: rtl/vss_end_logic.sv
module vss_end_logic #(
   parameter int unsigned ELEM_W = vss_pkg::VSS_ELEM_W,
   parameter int unsigned SUB_W  = vss_pkg::VSS_SUB_W,
   parameter int unsigned SIDES  = vss_pkg::VSS_SIDES
) (
   input  logic [ELEM_W-1:0] vl,
   input  logic [SIDES-1:0]  elem_end,
   input  logic [SIDES-1:0]  sub_end,
   input  logic [ELEM_W-1:0] elem [SIDES],
   output logic              loop_end,
   output logic              done
);
   logic [SIDES-1:0] side_fin, side_ovr;

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      assign side_fin[s] = elem_end[s] & sub_end[s];
      assign side_ovr[s] = sub_end[s] & (elem[s] == vl);
   end

   assign loop_end = |side_fin;
   assign done     = |side_ovr;
endmodule

// File: rtl/vec_step_seq.sv
module vec_step_seq #(
   parameter int unsigned ELEM_W = vss_pkg::VSS_ELEM_W,
   parameter int unsigned SUB_W  = vss_pkg::VSS_SUB_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vec_mode,
   input  logic              step,
   input  logic [ELEM_W-1:0] vl,
   input  logic [SUB_W-1:0]  subvl,
   input  logic              src_pack,
   input  logic              dst_unpack,
   output logic [ELEM_W-1:0] src_elem,
   output logic [SUB_W-1:0]  src_sub,
   output logic [ELEM_W-1:0] dst_elem,
   output logic [SUB_W-1:0]  dst_sub,
   output logic              src_end,
   output logic              dst_end,
   output logic              loop_end,
   output logic              done
);
   localparam int unsigned SIDES = vss_pkg::VSS_SIDES;

   if (ELEM_W < 2) begin : g_bad_elem_w
      $error("vec_step_seq: ELEM_W must be at least 2");
   end
   if (SUB_W < 1 || SUB_W > 4) begin : g_bad_sub_w
      $error("vec_step_seq: SUB_W must be 1 to 4");
   end

   logic [ELEM_W-1:0] last_elem;
   logic [SIDES-1:0]  order_bits;
   logic [SIDES-1:0]  elem_end, sub_end;
   logic [ELEM_W-1:0] elem [SIDES];
   logic [SUB_W-1:0]  sub  [SIDES];
   logic              adv, clr, fin;

   assign order_bits[vss_pkg::SIDE_SRC] = src_pack;
   assign order_bits[vss_pkg::SIDE_DST] = dst_unpack;

   assign adv = step & vec_mode & ~fin;
   assign clr = step & (~vec_mode | fin);

   vss_last_calc #(.ELEM_W(ELEM_W)) u_last (
      .vl        (vl),
      .last_elem (last_elem)
   );

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      vss_side #(.ELEM_W(ELEM_W), .SUB_W(SUB_W)) u_side (
         .clk        (clk),
         .rst        (rst),
         .adv        (adv),
         .clr        (clr),
         .order      (vss_pkg::vss_order_e'(order_bits[s])),
         .last_elem  (last_elem),
         .subvl      (subvl),
         .elem_o     (elem[s]),
         .sub_o      (sub[s]),
         .elem_end_o (elem_end[s]),
         .sub_end_o  (sub_end[s])
      );
   end

   vss_end_logic #(.ELEM_W(ELEM_W), .SUB_W(SUB_W), .SIDES(SIDES)) u_end (
      .vl       (vl),
      .elem_end (elem_end),
      .sub_end  (sub_end),
      .elem     (elem),
      .loop_end (fin),
      .done     (done)
   );

   assign src_elem = elem[vss_pkg::SIDE_SRC];
   assign src_sub  = sub[vss_pkg::SIDE_SRC];
   assign dst_elem = elem[vss_pkg::SIDE_DST];
   assign dst_sub  = sub[vss_pkg::SIDE_DST];
   assign src_end  = elem_end[vss_pkg::SIDE_SRC];
   assign dst_end  = elem_end[vss_pkg::SIDE_DST];
   assign loop_end = fin;
endmodule

// File: rtl/vss_checks.sv
module vss_checks #(
   parameter int unsigned ELEM_W = vss_pkg::VSS_ELEM_W,
   parameter int unsigned SUB_W  = vss_pkg::VSS_SUB_W
) (
   input logic              clk,
   input logic              rst,
   input logic              vec_mode,
   input logic              step,
   input logic [ELEM_W-1:0] vl,
   input logic [SUB_W-1:0]  subvl,
   input logic              src_pack,
   input logic              dst_unpack,
   input logic [ELEM_W-1:0] src_elem,
   input logic [SUB_W-1:0]  src_sub,
   input logic [ELEM_W-1:0] dst_elem,
   input logic [SUB_W-1:0]  dst_sub,
   input logic              src_end,
   input logic              dst_end,
   input logic              loop_end,
   input logic              done
);
   AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
      !step |=> ($stable(src_elem) && $stable(src_sub) && $stable(dst_elem) && $stable(dst_sub))); // R8

   AST_CLEAR_AT_END: assert property (@(posedge clk) disable iff (rst)
      (step && (loop_end || !vec_mode)) |=> (src_elem == '0 && src_sub == '0 && dst_elem == '0 && dst_sub == '0)); // R7

   AST_SRC_INNER_SUB: assert property (@(posedge clk) disable iff (rst)
      (step && vec_mode && !loop_end && !src_pack && src_sub != subvl) |=> (src_sub == $past(src_sub) + SUB_W'(1))); // R2

   AST_SRC_OUTER_ELEM: assert property (@(posedge clk) disable iff (rst)
      (step && vec_mode && !loop_end && src_pack && !src_end) |=> (src_elem == $past(src_elem) + ELEM_W'(1))); // R3

   AST_DST_OUTER_ELEM: assert property (@(posedge clk) disable iff (rst)
      (step && vec_mode && !loop_end && dst_unpack && !dst_end) |=> (dst_elem == $past(dst_elem) + ELEM_W'(1))); // R4

   AST_END_NEEDS_SIDE: assert property (@(posedge clk) disable iff (rst)
      loop_end |-> (src_end || dst_end)); // R6

   AST_ZERO_VL_ELEM: assert property (@(posedge clk) disable iff (rst)
      (vl == '0 && src_elem == '0 && $stable(vl)) |=> (src_elem == '0)); // R9
endmodule

bind vec_step_seq vss_checks #(.ELEM_W(ELEM_W), .SUB_W(SUB_W)) u_vss_checks (
   .clk        (clk),
   .rst        (rst),
   .vec_mode   (vec_mode),
   .step       (step),
   .vl         (vl),
   .subvl      (subvl),
   .src_pack   (src_pack),
   .dst_unpack (dst_unpack),
   .src_elem   (src_elem),
   .src_sub    (src_sub),
   .dst_elem   (dst_elem),
   .dst_sub    (dst_sub),
   .src_end    (src_end),
   .dst_end    (dst_end),
   .loop_end   (loop_end),
   .done       (done)
);

// File: tb/vec_step_seq_test.sv
`timescale 1ns/1ps
module vec_step_seq_test;
   localparam int EW = 7;
   localparam int SW = 2;
   localparam int RW = 2*EW + 2*SW + 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          vec_mode = 1'b0;
   logic          step = 1'b0;
   logic [EW-1:0] vl = '0;
   logic [SW-1:0] subvl = '0;
   logic          src_pack = 1'b0;
   logic          dst_unpack = 1'b0;
   logic [EW-1:0] src_elem, dst_elem;
   logic [SW-1:0] src_sub, dst_sub;
   logic          src_end, dst_end, loop_end, done;

   int n_checks = 0;
   int n_fail   = 0;

   logic [RW-1:0] exp_q [$];
   string         tag_q [$];

   // bench model of the loop position
   logic [EW-1:0] m_se = '0, m_de = '0;
   logic [SW-1:0] m_ss = '0, m_ds = '0;

   always #4 clk = ~clk;

   vec_step_seq #(.ELEM_W(EW), .SUB_W(SW)) uut (
      .clk(clk), .rst(rst), .vec_mode(vec_mode), .step(step), .vl(vl),
      .subvl(subvl), .src_pack(src_pack), .dst_unpack(dst_unpack),
      .src_elem(src_elem), .src_sub(src_sub), .dst_elem(dst_elem),
      .dst_sub(dst_sub), .src_end(src_end), .dst_end(dst_end),
      .loop_end(loop_end), .done(done)
   );

   function automatic logic [EW-1:0] last_of(input logic [EW-1:0] v);
      return (v == 0) ? '0 : v - 1'b1;
   endfunction

   function automatic logic [RW-1:0] model_vec();
      logic se, de, le, dn;
      se = (m_se == last_of(vl));
      de = (m_de == last_of(vl));
      le = (se && m_ss == subvl) || (de && m_ds == subvl);
      dn = (m_ss == subvl && m_se == vl) || (m_ds == subvl && m_de == vl);
      return {m_se, m_ss, m_de, m_ds, se, de, le, dn};
   endfunction

   function automatic logic [RW-1:0] actual_vec();
      return {src_elem, src_sub, dst_elem, dst_sub, src_end, dst_end, loop_end, done};
   endfunction

   task automatic compare(input logic [RW-1:0] exp_v, input string tag);
      logic [RW-1:0] act;
      act = actual_vec();
      n_checks++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
      end
   endtask

   task automatic side_next(inout logic [EW-1:0] e, inout logic [SW-1:0] s, input logic outer);
      logic [EW-1:0] lst;
      lst = last_of(vl);
      if (outer) begin
         if (e == lst) begin
            e = '0;
            if (s != subvl) s = s + 1'b1;
         end else e = e + 1'b1;
      end else begin
         if (s == subvl) begin
            s = '0;
            if (e != lst) e = e + 1'b1;
         end else s = s + 1'b1;
      end
   endtask

   // driver: one step pulse, expected result pushed to the scoreboard
   task automatic do_step(input string tag);
      logic [RW-1:0] cur;
      @(negedge clk);
      cur = model_vec();
      if (!vec_mode || cur[1]) begin
         m_se = '0; m_ss = '0; m_de = '0; m_ds = '0;
      end else begin
         side_next(m_se, m_ss, src_pack);
         side_next(m_de, m_ds, dst_unpack);
      end
      exp_q.push_back(model_vec());
      tag_q.push_back(tag);
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
   endtask

   task automatic check_now(input string tag);
      @(negedge clk);
      compare(model_vec(), tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      m_se = '0; m_ss = '0; m_de = '0; m_ds = '0;
   endtask

   // monitor: pops expected items after each accepted step edge
   initial begin
      forever begin
         @(posedge clk);
         if (step && !rst) begin
            #2;
            if (exp_q.size() > 0) begin
               logic [RW-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               compare(e, t);
            end
         end
      end
   end

   initial begin
      #(8 * 100000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check_now("R1 reset state");

      // sub-element inner on both sides
      vec_mode = 1'b1; vl = 7'd3; subvl = 2'd1;
      for (int i = 0; i < 7; i++) do_step("R2 R5 R6 inner order");

      // source outer, destination inner
      src_pack = 1'b1; dst_unpack = 1'b0; vl = 7'd4; subvl = 2'd2;
      for (int i = 0; i < 13; i++) do_step("R3 R4 R6 pack source");

      // source inner, destination outer, different shape
      src_pack = 1'b0; dst_unpack = 1'b1; vl = 7'd2; subvl = 2'd3;
      for (int i = 0; i < 9; i++) do_step("R4 R5 R6 unpack destination");

      // hold with no strobe
      for (int i = 0; i < 3; i++) do_step("R4 setup");
      repeat (4) @(negedge clk);
      check_now("R8 hold without step");

      // scalar step clears
      vec_mode = 1'b0;
      do_step("R7 scalar clear");
      vec_mode = 1'b1;

      // zero length
      vl = 7'd0; subvl = 2'd0; src_pack = 1'b0; dst_unpack = 1'b0;
      check_now("R9 R10 zero length state");
      do_step("R9 R7 zero length end");
      subvl = 2'd3;
      for (int i = 0; i < 5; i++) do_step("R9 R10 zero length subs");
      src_pack = 1'b1; dst_unpack = 1'b1;
      for (int i = 0; i < 5; i++) do_step("R9 zero length outer");

      // reset in mid loop
      vl = 7'd5; subvl = 2'd1; src_pack = 1'b0; dst_unpack = 1'b1;
      for (int i = 0; i < 4; i++) do_step("R2 R4 before reset");
      do_reset();
      check_now("R1 reset mid loop");

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule